// File: doc/BRIEF.md
# Paged Program Counter Unit

This block holds the 13-bit program counter of a small microcontroller core and decides its next value every clock. The low byte of the counter is visible to the core as an ordinary readable and writable byte. The upper five bits can never be written directly. They are filled from a separate 5-bit page latch that the core writes through its own port.

The latch feeds the counter in two different ways. A low-byte write takes all five latch bits. A jump or call takes only latch bits 4:3 as the page select, and the 11-bit opcode address field supplies the rest. A return loads the full address popped from the return stack and uses no latch bits at all.

When no load happens and stepping is enabled, the counter advances by one. The unit also offers the address of the next sequential instruction, so that the stack outside this block can save it on a call.

Top module: `pc_paged_unit`

## Requirements
- R1: While `rst_n` is low, `pc` reads 0 and the page latch is cleared. After reset, a low-byte write with no prior latch write therefore gives `pc[12:8]` = 0.
- R2: `pc_lo` always equals `pc[7:0]`.
- R3: After a cycle with `lo_wr` high and no higher-priority event, `pc` = {latch[4:0], `lo_wdata`}. A latch write in the same cycle does not affect this result; the value the latch held before that edge is used.
- R4: After a cycle with `br_en` high and no return, `pc` = {latch[4:3], `br_field[10:0]`}. Latch bits 2:0 play no part.
- R5: After a cycle with `ret_en` high, `pc` = `ret_addr`, whatever the latch holds.
- R6: The page latch takes `lat_wdata[4:0]` only on a cycle with `lat_wr` high. Returns, jumps, calls, low-byte writes and increments leave it unchanged.
- R7: A low-byte write never carries into or borrows from the upper bits. A computed jump that steps past a 256-word boundary lands at the start of the same block, with the upper bits still taken from the latch.
- R8: With no load event, `step_en` high advances `pc` by one modulo 8192, so 8191 is followed by 0. With `step_en` low, `pc` holds its value.
- R9: When load events coincide, the winner is chosen in this order: reset, then return, then jump or call, then low-byte write, then increment.
- R10: `push_addr` always equals (`pc` + 1) modulo 8192.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Advance to the next sequential address |
| lo_wr | input | 1 | Write strobe for the low byte |
| lo_wdata | input | 8 | Value written to the low byte |
| br_en | input | 1 | Jump or call strobe |
| br_field | input | 11 | Address field taken from the opcode |
| ret_en | input | 1 | Return strobe |
| ret_addr | input | 13 | Full address popped from the return stack |
| lat_wr | input | 1 | Page latch write strobe |
| lat_wdata | input | 5 | Value written to the page latch |
| pc | output | 13 | Current program counter |
| pc_lo | output | 8 | Readable low byte of the counter |
| push_addr | output | 13 | Next sequential address, offered for a push |

## Verification
The bench targets several corner cases, each of which exposes a specific fault:
- **Wrap at the top of the address space.** A unit that saturates at 8191 fails here, and so does one whose increment carries into a fourteenth bit.
- **Computed jump at a 256-word boundary.** A design that carries the low-byte sum into the upper bits leaves the block instead of wrapping within it.
- **Latch written in the same cycle as the low byte.** A design that forwards the new latch value gives the wrong upper bits.
- **Jump with latch bits 2:0 set.** A design that uses all five latch bits lands on the wrong page.
- **All strobes raised together.** A mistake in the priority order shows up as the wrong winner.

Random traffic with a fixed seed mixes these events freely. After every cycle the bench compares the counter, the low byte and the push address against a reference model.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    // Which source wins the program counter update this cycle.
    typedef enum logic [2:0] {
        PCU_SEL_HOLD = 3'd0,
        PCU_SEL_INC  = 3'd1,
        PCU_SEL_LO   = 3'd2,
        PCU_SEL_BR   = 3'd3,
        PCU_SEL_RET  = 3'd4
    } pcu_sel_e;

endpackage

// File: rtl/pcu_arbiter.sv
module pcu_arbiter
    import pcu_pkg::*;
(
    input  logic     ret_en,
    input  logic     br_en,
    input  logic     lo_wr,
    input  logic     step_en,
    output pcu_sel_e sel
);

    // Fixed priority: return, then jump/call, then low-byte write, then step.
    always_comb begin
        if (ret_en)       sel = PCU_SEL_RET;
        else if (br_en)   sel = PCU_SEL_BR;
        else if (lo_wr)   sel = PCU_SEL_LO;
        else if (step_en) sel = PCU_SEL_INC;
        else              sel = PCU_SEL_HOLD;
    end

endmodule

// File: rtl/pcu_page_latch.sv
module pcu_page_latch #(
    parameter int LAT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [LAT_W-1:0] wdata,
    output logic [LAT_W-1:0] lat
);

    logic [LAT_W-1:0] lat_d, lat_q;

    always_comb begin
        lat_d = lat_q;
        if (wr) lat_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= lat_d;
    end

    assign lat = lat_q;

endmodule

// File: rtl/pcu_next_pc.sv
module pcu_next_pc
    import pcu_pkg::*;
#(
    parameter int PC_W  = 13,
    parameter int LO_W  = 8,
    parameter int BR_W  = 11,
    parameter int LAT_W = 5
) (
    input  pcu_sel_e         sel,
    input  logic [PC_W-1:0]  pc_cur,
    input  logic [LAT_W-1:0] lat,
    input  logic [LO_W-1:0]  lo_wdata,
    input  logic [BR_W-1:0]  br_field,
    input  logic [PC_W-1:0]  ret_addr,
    output logic [PC_W-1:0]  pc_seq,
    output logic [PC_W-1:0]  pc_nxt
);

    localparam int HI_W = PC_W - LO_W;   // upper bits filled on a low-byte write
    localparam int PG_W = PC_W - BR_W;   // page bits filled on a jump or call

    logic [PC_W-1:0] lo_target;
    logic [PC_W-1:0] br_target;

    // Next sequential address; the sum is truncated to PC_W bits, so it wraps.
    assign pc_seq = pc_cur + PC_W'(1);

    // Low-byte write: the latch supplies the upper bits, nothing comes from pc_cur.
    assign lo_target = {lat[HI_W-1:0], lo_wdata};

    // Jump or call: only the top PG_W bits of the latch are used.
    assign br_target = {lat[HI_W-1 -: PG_W], br_field};

    always_comb begin
        unique case (sel)
            PCU_SEL_RET: pc_nxt = ret_addr;
            PCU_SEL_BR:  pc_nxt = br_target;
            PCU_SEL_LO:  pc_nxt = lo_target;
            PCU_SEL_INC: pc_nxt = pc_seq;
            default:     pc_nxt = pc_cur;
        endcase
    end

endmodule

// File: rtl/pc_paged_unit.sv
module pc_paged_unit
    import pcu_pkg::*;
#(
    parameter int PC_W  = 13,
    parameter int LO_W  = 8,
    parameter int BR_W  = 11,
    parameter int LAT_W = PC_W - LO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic              lo_wr,
    input  logic [LO_W-1:0]   lo_wdata,
    input  logic              br_en,
    input  logic [BR_W-1:0]   br_field,
    input  logic              ret_en,
    input  logic [PC_W-1:0]   ret_addr,
    input  logic              lat_wr,
    input  logic [LAT_W-1:0]  lat_wdata,
    output logic [PC_W-1:0]   pc,
    output logic [LO_W-1:0]   pc_lo,
    output logic [PC_W-1:0]   push_addr
);

    typedef struct packed {
        logic [PC_W-1:0] pc;
    } pcu_state_t;

    pcu_state_t       st_d, st_q;
    pcu_sel_e         sel;
    logic [LAT_W-1:0] lat_q;
    logic [PC_W-1:0]  pc_seq;
    logic [PC_W-1:0]  pc_nxt;

    pcu_arbiter u_arb (
        .ret_en  (ret_en),
        .br_en   (br_en),
        .lo_wr   (lo_wr),
        .step_en (step_en),
        .sel     (sel)
    );

    pcu_page_latch #(.LAT_W(LAT_W)) u_lat (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (lat_wr),
        .wdata (lat_wdata),
        .lat   (lat_q)
    );

    pcu_next_pc #(
        .PC_W  (PC_W),
        .LO_W  (LO_W),
        .BR_W  (BR_W),
        .LAT_W (LAT_W)
    ) u_nxt (
        .sel      (sel),
        .pc_cur   (st_q.pc),
        .lat      (lat_q),
        .lo_wdata (lo_wdata),
        .br_field (br_field),
        .ret_addr (ret_addr),
        .pc_seq   (pc_seq),
        .pc_nxt   (pc_nxt)
    );

    always_comb begin
        st_d    = st_q;
        st_d.pc = pc_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pc        = st_q.pc;
    assign pc_lo     = st_q.pc[LO_W-1:0];
    assign push_addr = pc_seq;

endmodule

// File: rtl/pcu_checker.sv
module pcu_checker #(
    parameter int PC_W  = 13,
    parameter int LO_W  = 8,
    parameter int BR_W  = 11,
    parameter int LAT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             step_en,
    input logic             lo_wr,
    input logic [LO_W-1:0]  lo_wdata,
    input logic             br_en,
    input logic [BR_W-1:0]  br_field,
    input logic             ret_en,
    input logic [PC_W-1:0]  ret_addr,
    input logic             lat_wr,
    input logic [LAT_W-1:0] lat_wdata,
    input logic [LAT_W-1:0] lat_q,
    input logic [PC_W-1:0]  pc,
    input logic [PC_W-1:0]  push_addr
);

    localparam int PG_W = PC_W - BR_W;

    a_r3_lo_write: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_wr && !br_en && !ret_en) |=> pc == {$past(lat_q), $past(lo_wdata)});

    a_r4_branch: assert property (@(posedge clk) disable iff (!rst_n)
        (br_en && !ret_en) |=> pc == {$past(lat_q[LAT_W-1 -: PG_W]), $past(br_field)});

    a_r5_return: assert property (@(posedge clk) disable iff (!rst_n)
        ret_en |=> pc == $past(ret_addr));

    a_r6_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !lat_wr |=> $stable(lat_q));

    a_r6_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
        lat_wr |=> lat_q == $past(lat_wdata));

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !lo_wr && !br_en && !ret_en) |=> $stable(pc));

    a_r10_step_uses_push: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !lo_wr && !br_en && !ret_en) |=> pc == $past(push_addr));

endmodule

bind pc_paged_unit pcu_checker #(
    .PC_W  (PC_W),
    .LO_W  (LO_W),
    .BR_W  (BR_W),
    .LAT_W (LAT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (step_en),
    .lo_wr     (lo_wr),
    .lo_wdata  (lo_wdata),
    .br_en     (br_en),
    .br_field  (br_field),
    .ret_en    (ret_en),
    .ret_addr  (ret_addr),
    .lat_wr    (lat_wr),
    .lat_wdata (lat_wdata),
    .lat_q     (lat_q),
    .pc        (pc),
    .push_addr (push_addr)
);

// File: tb/sim_pc_paged_unit.sv
`timescale 1ns/1ps
module sim_pc_paged_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_en = 1'b0, lo_wr = 1'b0, br_en = 1'b0, ret_en = 1'b0, lat_wr = 1'b0;
    logic [7:0]  lo_wdata = '0;
    logic [10:0] br_field = '0;
    logic [12:0] ret_addr = '0;
    logic [4:0]  lat_wdata = '0;
    logic [12:0] pc, push_addr;
    logic [7:0]  pc_lo;

    int checks = 0;
    int errors = 0;
    logic [12:0] m_pc = '0;
    logic [4:0]  m_lat = '0;

    always #5 clk = ~clk;

    pc_paged_unit u0 (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .lo_wr(lo_wr), .lo_wdata(lo_wdata),
        .br_en(br_en), .br_field(br_field), .ret_en(ret_en), .ret_addr(ret_addr),
        .lat_wr(lat_wr), .lat_wdata(lat_wdata), .pc(pc), .pc_lo(pc_lo), .push_addr(push_addr)
    );

    // Reference next PC, written from the requirements.
    function automatic logic [12:0] ref_next(input logic [12:0] cur, input logic [4:0] lat);
        if (ret_en)       return ret_addr;
        if (br_en)        return {lat[4:3], br_field};
        if (lo_wr)        return {lat, lo_wdata};
        if (step_en)      return 13'((int'(cur) + 1) % 8192);
        return cur;
    endfunction

    function automatic string tag_of();
        if (ret_en)  return "R5/R9";
        if (br_en)   return "R4/R9";
        if (lo_wr)   return "R3/R7";
        return "R8";
    endfunction

    task automatic chk(input string req, input logic [12:0] act, input logic [12:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_outputs(input string req);
        chk(req, pc, m_pc);
        chk("R2", {5'd0, pc_lo}, {5'd0, m_pc[7:0]});
        chk("R10", push_addr, 13'((int'(m_pc) + 1) % 8192));
    endtask

    // Inputs are set at the negedge; this advances one edge and checks.
    task automatic cycle();
        string t;
        logic [12:0] nxt;
        t = tag_of();
        nxt = ref_next(m_pc, m_lat);
        if (lat_wr) m_lat = lat_wdata;
        m_pc = nxt;
        @(posedge clk);
        #2;
        check_outputs(t);
        @(negedge clk);
    endtask

    task automatic idle();
        step_en = 0; lo_wr = 0; br_en = 0; ret_en = 0; lat_wr = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        m_pc = '0; m_lat = '0;
        @(posedge clk); #2;
        check_outputs("R1");
        @(negedge clk);
        rst_n = 1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd1234));
        @(negedge clk);
        do_reset();

        // R1: latch cleared by reset, visible through a low-byte write.
        idle(); lo_wr = 1; lo_wdata = 8'h5A; cycle();
        chk("R1", pc, 13'h005A);

        // R8: hold when step_en low.
        idle(); cycle(); cycle();

        // R6/R3: latch write alongside a low-byte write uses the old latch.
        idle(); lat_wr = 1; lat_wdata = 5'h1F; lo_wr = 1; lo_wdata = 8'h10; cycle();
        chk("R3", pc, 13'h0010);
        idle(); lo_wr = 1; lo_wdata = 8'h20; cycle();
        chk("R6", pc, 13'h1F20);

        // R8: wrap from 8191 to 0.
        idle(); ret_en = 1; ret_addr = 13'h1FFE; cycle();
        idle(); step_en = 1; cycle(); cycle();
        chk("R8", pc, 13'h0000);

        // R8: normal increment carries across a 256-word boundary.
        idle(); ret_en = 1; ret_addr = 13'h02FF; cycle();
        idle(); step_en = 1; cycle();
        chk("R8", pc, 13'h0300);

        // R7: computed jump past 0x2FF wraps within its block.
        idle(); lat_wr = 1; lat_wdata = 5'h02; cycle();
        idle(); lo_wr = 1; lo_wdata = 8'hFF; cycle();
        idle(); lo_wr = 1; lo_wdata = 8'(8'hFF + 8'h03); cycle();
        chk("R7", pc, 13'h0202);

        // R4: latch bits 2:0 set must not leak into a jump.
        idle(); lat_wr = 1; lat_wdata = 5'b10111; cycle();
        idle(); br_en = 1; br_field = 11'h123; cycle();
        chk("R4", pc, 13'h1123);

        // R5/R6: return ignores the latch and leaves it unchanged.
        idle(); ret_en = 1; ret_addr = 13'h0ABC; cycle();
        chk("R5", pc, 13'h0ABC);
        idle(); lo_wr = 1; lo_wdata = 8'h01; cycle();
        chk("R6", pc, 13'h1701);

        // R9: all strobes at once, then peel them off.
        idle(); step_en = 1; lo_wr = 1; br_en = 1; ret_en = 1;
        ret_addr = 13'h0777; br_field = 11'h055; lo_wdata = 8'h99; cycle();
        chk("R9", pc, 13'h0777);
        ret_en = 0; cycle();
        chk("R9", pc, 13'h1055);
        br_en = 0; cycle();
        chk("R9", pc, 13'h1799);

        // R1/R9: reset beats everything.
        ret_en = 1; br_en = 1;
        do_reset();

        // Random traffic.
        for (int i = 0; i < 3000; i++) begin
            idle();
            step_en   = ($urandom_range(0, 3) != 0);
            lo_wr     = ($urandom_range(0, 7) == 0);
            br_en     = ($urandom_range(0, 7) == 0);
            ret_en    = ($urandom_range(0, 9) == 0);
            lat_wr    = ($urandom_range(0, 5) == 0);
            lo_wdata  = 8'($urandom);
            br_field  = 11'($urandom);
            ret_addr  = 13'($urandom);
            lat_wdata = 5'($urandom);
            cycle();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule